// File: doc/BRIEF.md
# Two-Section Decade Counter with Clear and Preset

This block models a ripple-style decade counter with a synchronous design. It has two counting sections that are clocked independently. The low section divides by two and drives bit 0 of the output (QA). The high section divides by five and drives bits 3..1 (QD QC QB). Each section advances when its count source falls from high to low. That falling edge is seen on the system clock.

Two gated pairs of level inputs override counting. When both clear inputs are high, the counter is forced to zero. When both preset inputs are high, the counter is forced to nine (1001), and this preset wins over clear.

The block can run in a decimal (BCD) mode or in a symmetric bi-quinary mode. Each mode comes from feeding one output back into a count input. To avoid a combinational loop, a per-section select input picks the count source: the external pin, QA or QD. An edge produced inside the block reaches the other section one system clock later.

Top module: `decade_pair_counter`

## Requirements
- R1: While rst_ni is low, q_o is 0000 and both edge-sample registers are zero, so a source that is high at release is not counted.
- R2: If clr_a_i and clr_b_i are both high and nine_a_i and nine_b_i are not both high at a clock edge, q_o is 0000 after that edge.
- R3: If nine_a_i and nine_b_i are both high at a clock edge, q_o is 1001 after that edge, whatever the clear inputs are.
- R4: A falling edge is only accepted if neither override was active in the sampling cycle or in the cycle before it. Edges that fall inside that window are dropped, and counting resumes on the next fresh falling edge.
- R5: A falling edge on the low section's source inverts q_o[0] at the first clock edge at which the source is sampled low after being sampled high.
- R6: A falling edge on the high section's source steps q_o[3:1] through 000, 001, 010, 011, 100 and then wraps from 100 back to 000.
- R7: The source selects src_a_i and src_b_i are encoded as follows: 00 or 11 is the external pin, 01 is q_o[0] and 10 is q_o[3]. A fall of an internal source is counted one clock after the edge that produced it.
- R8: With src_b_i=01 and pulses on cnt_a_i, q_o takes the binary values 0 through 9 and then wraps to 0.
- R9: With src_a_i=10 and pulses on cnt_b_i, q_o[0] stays low for five pulses and high for the next five, giving a 50% duty cycle over ten pulses.
- R10: An external count pin that is not selected as a source has no effect on q_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_a_i | input | 1 | External count pin of the low section |
| cnt_b_i | input | 1 | External count pin of the high section |
| src_a_i | input | 2 | Count source select for the low section |
| src_b_i | input | 2 | Count source select for the high section |
| clr_a_i | input | 1 | Clear gate, first input |
| clr_b_i | input | 1 | Clear gate, second input |
| nine_a_i | input | 1 | Preset-to-nine gate, first input |
| nine_b_i | input | 1 | Preset-to-nine gate, second input |
| q_o | output | 4 | Count value: [0]=QA, [3:1]=QD QC QB |

## Verification
Overrides and falls on an external pin take effect at the next clock edge. A rippled fall from QA or QD lands one edge after that. The bench drives inputs on the falling clock edge and holds every pin level for two clock periods, then samples two periods later, so rippled results are already settled when they are checked. The override window checks instead sample one period after each stimulus, which shows that the forced value appears at the very next edge. They also show that an edge falling in the cycle right after an override is released is dropped.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [1:0] {
    SRC_PIN  = 2'b00,
    SRC_QA   = 2'b01,
    SRC_QD   = 2'b10,
    SRC_PIN2 = 2'b11
  } src_sel_e;

  function automatic logic pick_src(input logic [1:0] sel, input logic pin,
                                    input logic qa, input logic qd);
    logic r;
    case (src_sel_e'(sel))
      SRC_QA:  r = qa;
      SRC_QD:  r = qd;
      default: r = pin;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/dpc_fall.sv
module dpc_fall (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;

  assign fall_o = prev_q & ~lvl_i;

  // R1: nothing is reported in the first cycle after reset is released
  p_no_fall_after_rst_r1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> !fall_o);
endmodule

// File: rtl/dpc_div2.sv
module dpc_div2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic clr_i,
  input  logic set_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
    else if (inc_i) q_o <= ~q_o;

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i && !set_i) |=> $stable(q_o));
  p_toggle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && !set_i) |=> (q_o != $past(q_o)));
endmodule

// File: rtl/dpc_divn.sv
module dpc_divn #(
  parameter int unsigned MOD = 5,
  localparam int unsigned W  = $clog2(MOD)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  input  logic         set_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  logic [W-1:0] nxt;

  always_comb begin
    if (q_o >= LAST) nxt = '0;   // wrap, and recover from unused codes
    else             nxt = q_o + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    q_o <= '0;
    else if (set_i) q_o <= LAST;
    else if (clr_i) q_o <= '0;
    else if (inc_i) q_o <= nxt;

  p_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o <= LAST);
  p_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && !set_i && q_o == LAST) |=> q_o == '0);
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/decade_pair_counter.sv
module decade_pair_counter #(
  parameter int unsigned HI_MOD = 5,
  localparam int unsigned HW    = $clog2(HI_MOD),
  localparam int unsigned QW    = HW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cnt_a_i,
  input  logic          cnt_b_i,
  input  logic [1:0]    src_a_i,
  input  logic [1:0]    src_b_i,
  input  logic          clr_a_i,
  input  logic          clr_b_i,
  input  logic          nine_a_i,
  input  logic          nine_b_i,
  output logic [QW-1:0] q_o
);
  import dpc_pkg::*;

  logic          qa;
  logic [HW-1:0] qh;
  logic          lvl_a, lvl_b, fall_a, fall_b;
  logic          clr, set, ovr, ovr_q, open_win;

  assign clr = clr_a_i & clr_b_i;
  assign set = nine_a_i & nine_b_i;
  assign ovr = clr | set;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ovr_q <= 1'b0;
    else         ovr_q <= ovr;

  // edges landing in or just after an override are dropped
  assign open_win = ~ovr & ~ovr_q;

  assign lvl_a = pick_src(src_a_i, cnt_a_i, qa, qh[HW-1]);
  assign lvl_b = pick_src(src_b_i, cnt_b_i, qa, qh[HW-1]);

  dpc_fall u_fall_a (.clk_i, .rst_ni, .lvl_i(lvl_a), .fall_o(fall_a));
  dpc_fall u_fall_b (.clk_i, .rst_ni, .lvl_i(lvl_b), .fall_o(fall_b));

  dpc_div2 u_lo (
    .clk_i, .rst_ni, .inc_i(fall_a & open_win),
    .clr_i(clr), .set_i(set), .q_o(qa)
  );

  dpc_divn #(.MOD(HI_MOD)) u_hi (
    .clk_i, .rst_ni, .inc_i(fall_b & open_win),
    .clr_i(clr), .set_i(set), .q_o(qh)
  );

  assign q_o = {qh, qa};

  p_nine_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set |=> (q_o == {HW'(HI_MOD - 1), 1'b1}));
  p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !set) |=> (q_o == '0));
  p_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovr && ovr_q) |=> $stable(q_o));
endmodule

// File: tb/sim_decade_pair_counter.sv
module sim_decade_pair_counter;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cnt_a = 1'b0, cnt_b = 1'b0;
  logic [1:0] src_a = 2'b00, src_b = 2'b00;
  logic       clr_a = 1'b0, clr_b = 1'b0, nine_a = 1'b0, nine_b = 1'b0;
  logic [3:0] q;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  decade_pair_counter u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cnt_a_i(cnt_a), .cnt_b_i(cnt_b),
    .src_a_i(src_a), .src_b_i(src_b), .clr_a_i(clr_a), .clr_b_i(clr_b),
    .nine_a_i(nine_a), .nine_b_i(nine_b), .q_o(q)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: q=%b expected %b", req, act, exp);
    end
  endtask

  task automatic pulse_a();
    cnt_a = 1'b1; tick(2); cnt_a = 1'b0; tick(2);
  endtask

  task automatic pulse_b();
    cnt_b = 1'b1; tick(2); cnt_b = 1'b0; tick(2);
  endtask

  task automatic do_clear();
    clr_a = 1'b1; clr_b = 1'b1; tick(1);
    clr_a = 1'b0; clr_b = 1'b0; tick(2);
  endtask

  task automatic t_reset();
    chk("R1 reset", q, 4'b0000);
    cnt_a = 1'b1; cnt_b = 1'b1;
    rst_ni = 1'b1; tick(1);
    chk("R1 no count on high source at release", q, 4'b0000);
    cnt_a = 1'b0; tick(1);
    chk("R5 first A fall after reset", q, 4'b0001);
    cnt_b = 1'b0; tick(1);
    chk("R6 first B fall after reset", q, 4'b0011);
    do_clear();
  endtask

  task automatic t_bcd();
    src_a = 2'b00; src_b = 2'b01;
    do_clear();
    for (int k = 1; k <= 12; k++) begin
      pulse_a();
      chk($sformatf("R8 bcd step %0d", k), q, 4'(k % 10));
    end
    // now at 2; step to 3, then check ripple timing on the fall to 4
    pulse_a();
    cnt_a = 1'b1; tick(2); cnt_a = 1'b0; tick(1);
    chk("R7 QA fall seen, high section not yet", q, 4'b0010);
    tick(1);
    chk("R7 high section one clock later", q, 4'b0100);
    pulse_b();
    chk("R10 unselected B pin ignored", q, 4'b0100);
  endtask

  task automatic t_biq();
    int highs = 0;
    src_a = 2'b10; src_b = 2'b00;
    do_clear();
    for (int k = 1; k <= 10; k++) begin
      pulse_b();
      chk($sformatf("R9 biquinary step %0d", k), q, {3'(k % 5), 1'((k / 5) % 2)});
      if (q[0]) highs++;
    end
    chk("R9 QA high for 5 of 10", 4'(highs), 4'd5);
    pulse_a();
    chk("R10 unselected A pin ignored", q, 4'b0000);
  endtask

  task automatic t_prio();
    src_a = 2'b00; src_b = 2'b00;
    for (int c = 0; c < 16; c++) begin
      logic [3:0] exp;
      do_clear();
      pulse_b();
      {clr_a, clr_b, nine_a, nine_b} = 4'(c);
      tick(1);
      if (c[1] && c[0])      exp = 4'b1001;
      else if (c[3] && c[2]) exp = 4'b0000;
      else                   exp = 4'b0010;
      chk($sformatf("R2 R3 R4 gates clr=%b%b nine=%b%b", c[3], c[2], c[1], c[0]), q, exp);
      {clr_a, clr_b, nine_a, nine_b} = 4'b0000;
      tick(2);
    end
  endtask

  task automatic t_window();
    src_a = 2'b00; src_b = 2'b11;
    do_clear();
    clr_a = 1'b1; clr_b = 1'b1;
    pulse_a();
    chk("R4 fall during clear dropped", q, 4'b0000);
    cnt_a = 1'b1; tick(2);
    clr_a = 1'b0; clr_b = 1'b0; cnt_a = 1'b0; tick(2);
    chk("R4 fall just after release dropped", q, 4'b0000);
    pulse_a();
    chk("R4 next fresh fall counted", q, 4'b0001);
    pulse_b();
    chk("R7 source 11 selects B pin", q, 4'b0011);
    nine_a = 1'b1; nine_b = 1'b1; tick(1);
    nine_a = 1'b0; nine_b = 1'b0; tick(2);
    chk("R3 preset nine", q, 4'b1001);
    pulse_b();
    chk("R6 wrap 100 to 000", q, 4'b0001);
  endtask

  initial begin
    tick(3);
    t_reset();
    t_bcd();
    t_biq();
    t_prio();
    t_window();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run incomplete, expected completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule